// File: doc/BRIEF.md
# Backplane Command Decode and Queue

This block sits between a synchronous backplane bus and a memory array. Every bus cycle may carry one transfer made of a parity bit, a tag, a source identifier, a byte mask and a 32-bit information field. The block registers each transfer and checks its parity. It then classifies the transfer by tag, function code and address. Requests that pass are written into a small first-in first-out command file. The memory side drains that file through a valid/ready pop port.

A command transfer holds a 4-bit function code in bits 31:28 and a longword address in bits 27:0. Write commands are followed on the bus by one or two write-data transfers. The command and its data share slots in the command file. The command becomes visible to the memory side only once all of its data has arrived, so a write is either complete in the file or absent.

Every transfer is answered two bus cycles after it appears. The answer is an acknowledge, a busy or an error code, or no code at all for an address that falls outside the configured memory size.

Top module: `cq_top`

## Requirements
- R1: Parity is even over parity bit, tag, identifier, mask and information together (XOR of all of them is 0). A transfer that fails this check is answered ERR and nothing of it is queued.
- R2: A transfer presented on the inputs in bus cycle k is answered on `cnf_code` in cycle k+2. The codes are 0 = none, 1 = ACK, 2 = BSY, 3 = ERR. A cycle with `in_valid` low is answered with code 0.
- R3: Tag 3'b001 marks a command/address transfer and tag 3'b010 marks write data. Any other tag is answered ERR. A write-data transfer that no accepted write command is waiting for is also answered ERR. Neither case queues anything.
- R4: Function codes are 1 read masked, 2 interlocked read masked, 3 extended (quadword) read, 4 write masked, 5 interlocked write masked and 6 extended (quadword) write masked. Codes 4 and 5 take one data transfer, code 6 takes two, and the rest take none. Any other code is answered ERR and not queued.
- R5: A command whose address is not below MEM_WORDS gets no confirmation (code 0) and is not queued.
- R6: A command is answered BSY, and nothing is queued, when the file's free slots are fewer than one plus its data-transfer count.
- R7: Data for an accepted write must arrive in the bus cycles that immediately follow the command, and each data transfer is answered ACK. The command and its data become poppable only together, in the cycle after the last data transfer is written.
- R8: If the cycle where data is due carries no transfer, a non-data transfer or bad parity, the write's entries already written are discarded. That cycle is answered ERR if it carried a transfer and 0 otherwise, and it is not itself processed.
- R9: Entries leave the pop port in arrival order. Each entry carries a data flag (0 command, 1 data), the identifier, the mask and the information field of its transfer. The head entry is held stable while `q_ready` is low.
- R10: The file never holds more than DEPTH entries, and slots freed by pops or discards are reused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A transfer is on the bus this cycle |
| in_par | input | 1 | Even parity bit of the transfer |
| in_tag | input | 3 | Transfer kind |
| in_id | input | ID_W | Source identifier |
| in_mask | input | MASK_W | Byte select |
| in_info | input | INFO_W | Command/address or write data |
| cnf_code | output | 2 | Confirmation for the transfer two cycles earlier |
| q_valid | output | 1 | A committed entry is at the head of the file |
| q_ready | input | 1 | Memory side takes the head entry |
| q_is_data | output | 1 | Head entry is write data |
| q_id | output | ID_W | Head entry identifier |
| q_mask | output | MASK_W | Head entry mask |
| q_info | output | INFO_W | Head entry information field |

## Verification
The bench builds the block with the default DEPTH of 4, 5-bit identifiers and MEM_WORDS set to 256. The small address range puts the first address outside memory a few bits away from zero. A depth of four lets an extended write plus one read fill the file exactly, so the next request reaches BSY, and a masked write meets BSY behind three reads. Broken write sequences are driven with a missing transfer, an intruding command and a data transfer with bad parity. Each one is followed by a full refill that proves the discarded slots came back.

// File: rtl/cq_pkg.sv
package cq_pkg;

  localparam int TAG_W = 3;
  localparam int FN_W  = 4;

  localparam logic [TAG_W-1:0] TAG_CMD  = 3'b001;
  localparam logic [TAG_W-1:0] TAG_WDAT = 3'b010;

  localparam logic [FN_W-1:0] FN_RD_MSK = 4'd1;
  localparam logic [FN_W-1:0] FN_RD_LCK = 4'd2;
  localparam logic [FN_W-1:0] FN_RD_EXT = 4'd3;
  localparam logic [FN_W-1:0] FN_WR_MSK = 4'd4;
  localparam logic [FN_W-1:0] FN_WR_LCK = 4'd5;
  localparam logic [FN_W-1:0] FN_WR_EXT = 4'd6;

  typedef enum logic [1:0] {
    CNF_NONE = 2'd0,
    CNF_ACK  = 2'd1,
    CNF_BSY  = 2'd2,
    CNF_ERR  = 2'd3
  } cnf_e;

  function automatic logic fn_known(input logic [FN_W-1:0] f);
    return (f >= FN_RD_MSK) && (f <= FN_WR_EXT);
  endfunction

  function automatic logic [1:0] fn_beats(input logic [FN_W-1:0] f);
    case (f)
      FN_WR_MSK, FN_WR_LCK: return 2'd1;
      FN_WR_EXT:            return 2'd2;
      default:              return 2'd0;
    endcase
  endfunction

  function automatic logic room_ok(input int occ, input int beats, input int depth);
    return (occ + beats + 1) <= depth;
  endfunction

endpackage

// File: rtl/cq_latch.sv
module cq_latch #(
  parameter int ID_W   = 5,
  parameter int MASK_W = 4,
  parameter int INFO_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_par,
  input  logic [cq_pkg::TAG_W-1:0] in_tag,
  input  logic [ID_W-1:0]          in_id,
  input  logic [MASK_W-1:0]        in_mask,
  input  logic [INFO_W-1:0]        in_info,
  output logic                     s_vld,
  output logic                     s_par,
  output logic [cq_pkg::TAG_W-1:0] s_tag,
  output logic [ID_W-1:0]          s_id,
  output logic [MASK_W-1:0]        s_mask,
  output logic [INFO_W-1:0]        s_info
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_vld  <= 1'b0;
      s_par  <= 1'b0;
      s_tag  <= '0;
      s_id   <= '0;
      s_mask <= '0;
      s_info <= '0;
    end else begin
      s_vld  <= in_valid;
      s_par  <= in_par;
      s_tag  <= in_tag;
      s_id   <= in_id;
      s_mask <= in_mask;
      s_info <= in_info;
    end
  end

endmodule

// File: rtl/cq_classify.sv
module cq_classify #(
  parameter int          ID_W      = 5,
  parameter int          MASK_W    = 4,
  parameter int          INFO_W    = 32,
  parameter int unsigned MEM_WORDS = 32'h0010_0000
) (
  input  logic                     s_par,
  input  logic [cq_pkg::TAG_W-1:0] s_tag,
  input  logic [ID_W-1:0]          s_id,
  input  logic [MASK_W-1:0]        s_mask,
  input  logic [INFO_W-1:0]        s_info,
  output logic                     par_ok,
  output logic                     is_cmd,
  output logic                     is_data,
  output logic                     fn_ok,
  output logic                     in_rng,
  output logic [1:0]               beats
);
  import cq_pkg::*;

  localparam int ADDR_W = INFO_W - FN_W;

  logic [FN_W-1:0]   fn;
  logic [ADDR_W-1:0] addr;

  assign fn   = s_info[INFO_W-1 -: FN_W];
  assign addr = s_info[ADDR_W-1:0];

  always_comb begin
    par_ok  = ~(^{s_par, s_tag, s_id, s_mask, s_info});
    is_cmd  = (s_tag == TAG_CMD);
    is_data = (s_tag == TAG_WDAT);
    fn_ok   = fn_known(fn);
    beats   = fn_beats(fn);
    in_rng  = (32'(addr) < 32'(MEM_WORDS));
  end

endmodule

// File: rtl/cq_ctrl.sv
module cq_ctrl #(
  parameter int DEPTH = 4,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_vld,
  input  logic             par_ok,
  input  logic             is_cmd,
  input  logic             is_data,
  input  logic             fn_ok,
  input  logic             in_rng,
  input  logic [1:0]       beats,
  input  logic [PTR_W-1:0] occ,
  output logic             wr_en,
  output logic             commit,
  output logic             abort,
  output logic             ev_busy,
  output logic             ev_accept,
  output logic             ev_pending,
  output logic [1:0]       cnf_code
);
  import cq_pkg::*;

  logic [1:0] need_q, need_d;
  cnf_e       cnf_q, cnf_d;

  always_comb begin
    cnf_d     = CNF_NONE;
    need_d    = need_q;
    wr_en     = 1'b0;
    commit    = 1'b0;
    abort     = 1'b0;
    ev_busy   = 1'b0;
    ev_accept = 1'b0;
    if (need_q != 2'd0) begin
      if (s_vld && par_ok && is_data) begin
        wr_en  = 1'b1;
        need_d = need_q - 2'd1;
        commit = (need_q == 2'd1);
        cnf_d  = CNF_ACK;
      end else begin
        abort  = 1'b1;
        need_d = 2'd0;
        cnf_d  = s_vld ? CNF_ERR : CNF_NONE;
      end
    end else if (s_vld) begin
      if (!par_ok || !is_cmd || !fn_ok) begin
        cnf_d = CNF_ERR;
      end else if (!in_rng) begin
        cnf_d = CNF_NONE;
      end else if (!room_ok(int'(occ), int'(beats), DEPTH)) begin
        cnf_d   = CNF_BSY;
        ev_busy = 1'b1;
      end else begin
        cnf_d     = CNF_ACK;
        wr_en     = 1'b1;
        commit    = (beats == 2'd0);
        need_d    = beats;
        ev_accept = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      need_q <= 2'd0;
      cnf_q  <= CNF_NONE;
    end else begin
      need_q <= need_d;
      cnf_q  <= cnf_d;
    end
  end

  assign ev_pending = (need_q != 2'd0);
  assign cnf_code   = cnf_q;

endmodule

// File: rtl/cq_file.sv
module cq_file #(
  parameter int DEPTH = 4,
  parameter int ENT_W = 42,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ENT_W-1:0] wr_ent,
  input  logic             commit,
  input  logic             abort,
  input  logic             pop,
  output logic             out_vld,
  output logic [ENT_W-1:0] out_ent,
  output logic [PTR_W-1:0] occ
);

  localparam int IDX_W = PTR_W - 1;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, cm_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[IDX_W-1:0]] <= wr_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      cm_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (abort)      wr_ptr <= cm_ptr;
      else if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (commit)     cm_ptr <= wr_ptr + PTR_W'(wr_en);
      if (pop)        rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign out_vld = (rd_ptr != cm_ptr);
  assign out_ent = mem[rd_ptr[IDX_W-1:0]];
  assign occ     = wr_ptr - rd_ptr;

endmodule

// File: rtl/cq_top.sv
module cq_top #(
  parameter int          DEPTH     = 4,
  parameter int          ID_W      = 5,
  parameter int          MASK_W    = 4,
  parameter int          INFO_W    = 32,
  parameter int unsigned MEM_WORDS = 32'h0010_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_par,
  input  logic [2:0]        in_tag,
  input  logic [ID_W-1:0]   in_id,
  input  logic [MASK_W-1:0] in_mask,
  input  logic [INFO_W-1:0] in_info,
  output logic [1:0]        cnf_code,
  output logic              q_valid,
  input  logic              q_ready,
  output logic              q_is_data,
  output logic [ID_W-1:0]   q_id,
  output logic [MASK_W-1:0] q_mask,
  output logic [INFO_W-1:0] q_info
);

  localparam int PTR_W = $clog2(DEPTH) + 1;
  localparam int ENT_W = 1 + ID_W + MASK_W + INFO_W;

  logic              s_vld, s_par;
  logic [2:0]        s_tag;
  logic [ID_W-1:0]   s_id;
  logic [MASK_W-1:0] s_mask;
  logic [INFO_W-1:0] s_info;

  logic       par_ok, is_cmd, is_data, fn_ok, in_rng;
  logic [1:0] beats;

  logic             wr_en, ev_commit, ev_abort, ev_busy, ev_accept, ev_pending, ev_pop;
  logic [PTR_W-1:0] occ;
  logic [ENT_W-1:0] head_ent;

  cq_latch #(.ID_W(ID_W), .MASK_W(MASK_W), .INFO_W(INFO_W)) u_latch (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_par(in_par), .in_tag(in_tag), .in_id(in_id),
    .in_mask(in_mask), .in_info(in_info),
    .s_vld(s_vld), .s_par(s_par), .s_tag(s_tag), .s_id(s_id),
    .s_mask(s_mask), .s_info(s_info)
  );

  cq_classify #(.ID_W(ID_W), .MASK_W(MASK_W), .INFO_W(INFO_W), .MEM_WORDS(MEM_WORDS)) u_cls (
    .s_par(s_par), .s_tag(s_tag), .s_id(s_id), .s_mask(s_mask), .s_info(s_info),
    .par_ok(par_ok), .is_cmd(is_cmd), .is_data(is_data), .fn_ok(fn_ok),
    .in_rng(in_rng), .beats(beats)
  );

  cq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .s_vld(s_vld), .par_ok(par_ok), .is_cmd(is_cmd), .is_data(is_data),
    .fn_ok(fn_ok), .in_rng(in_rng), .beats(beats), .occ(occ),
    .wr_en(wr_en), .commit(ev_commit), .abort(ev_abort), .ev_busy(ev_busy),
    .ev_accept(ev_accept), .ev_pending(ev_pending), .cnf_code(cnf_code)
  );

  assign ev_pop = q_valid && q_ready;

  cq_file #(.DEPTH(DEPTH), .ENT_W(ENT_W), .PTR_W(PTR_W)) u_file (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_ent({is_data, s_id, s_mask, s_info}),
    .commit(ev_commit), .abort(ev_abort), .pop(ev_pop),
    .out_vld(q_valid), .out_ent(head_ent), .occ(occ)
  );

  assign {q_is_data, q_id, q_mask, q_info} = head_ent;

endmodule

// File: rtl/cq_checker.sv
module cq_checker #(
  parameter int DEPTH  = 4,
  parameter int PTR_W  = 3,
  parameter int ID_W   = 5,
  parameter int MASK_W = 4,
  parameter int INFO_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_par,
  input logic [2:0]        in_tag,
  input logic [ID_W-1:0]   in_id,
  input logic [MASK_W-1:0] in_mask,
  input logic [INFO_W-1:0] in_info,
  input logic [1:0]        cnf_code,
  input logic              q_valid,
  input logic              q_ready,
  input logic [ID_W-1:0]   q_id,
  input logic [INFO_W-1:0] q_info,
  input logic              wr_en,
  input logic              ev_commit,
  input logic              ev_busy,
  input logic [PTR_W-1:0]  occ
);

  logic bad_par;
  assign bad_par = in_valid && (^{in_par, in_tag, in_id, in_mask, in_info});

  p_parity_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bad_par, 2) |-> (cnf_code == 2'd3));

  p_cnf_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnf_code != 2'd0) |-> $past(in_valid, 2));

  p_busy_no_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_busy |=> (occ <= $past(occ)));

  p_commit_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_valid) |-> $past(ev_commit));

  p_head_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_ready) |=> (q_valid && $stable(q_info) && $stable(q_id)));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PTR_W'(DEPTH));

  p_no_push_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (occ < PTR_W'(DEPTH)));

endmodule

bind cq_top cq_checker #(
  .DEPTH(DEPTH), .PTR_W(PTR_W), .ID_W(ID_W), .MASK_W(MASK_W), .INFO_W(INFO_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_par(in_par), .in_tag(in_tag),
  .in_id(in_id), .in_mask(in_mask), .in_info(in_info), .cnf_code(cnf_code),
  .q_valid(q_valid), .q_ready(q_ready), .q_id(q_id), .q_info(q_info),
  .wr_en(wr_en), .ev_commit(ev_commit), .ev_busy(ev_busy), .occ(occ)
);

// File: tb/cq_top_bench.sv
module cq_top_bench;

  localparam int MEMW = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_par = 1'b0, q_ready = 1'b0;
  logic [2:0]  in_tag = '0;
  logic [4:0]  in_id = '0;
  logic [3:0]  in_mask = '0;
  logic [31:0] in_info = '0;
  logic [1:0]  cnf_code;
  logic        q_valid, q_is_data;
  logic [4:0]  q_id;
  logic [3:0]  q_mask;
  logic [31:0] q_info;

  cq_top #(.DEPTH(4), .ID_W(5), .MASK_W(4), .INFO_W(32), .MEM_WORDS(MEMW)) u_cq_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_par(in_par), .in_tag(in_tag),
    .in_id(in_id), .in_mask(in_mask), .in_info(in_info), .cnf_code(cnf_code),
    .q_valid(q_valid), .q_ready(q_ready), .q_is_data(q_is_data), .q_id(q_id),
    .q_mask(q_mask), .q_info(q_info)
  );

  always #10 clk = ~clk;

  int vectors = 0, fails = 0;
  bit finished = 0;

  localparam logic [1:0] NONE = 2'd0, ACK = 2'd1, BSY = 2'd2, ERR = 2'd3;
  localparam logic [2:0] T_CMD = 3'b001, T_DAT = 3'b010;

  logic        h1_v = 0, h2_v = 0;
  logic [1:0]  h1_e, h2_e;
  string       h1_r, h2_r;
  logic [41:0] exq [16];
  int          exn = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] tag, input logic [4:0] id,
                      input logic [3:0] mask, input logic [31:0] info, input bit flip,
                      input logic [1:0] exp, input string req);
    @(negedge clk);
    if (h2_v) chk(h2_r, "cnf_code", 64'(cnf_code), 64'(h2_e));
    h2_v = h1_v; h2_e = h1_e; h2_r = h1_r;
    h1_v = 1'b1; h1_e = exp; h1_r = req;
    in_valid = v; in_tag = tag; in_id = id; in_mask = mask; in_info = info;
    in_par = (^{tag, id, mask, info}) ^ flip;
  endtask

  task automatic cmd(input logic [3:0] fn, input int addr, input logic [4:0] id,
                     input logic [1:0] exp, input string req);
    step(1'b1, T_CMD, id, 4'hF, {fn, 28'(addr)}, 1'b0, exp, req);
  endtask

  task automatic dat(input logic [31:0] d, input logic [3:0] m, input logic [4:0] id,
                     input logic [1:0] exp, input string req);
    step(1'b1, T_DAT, id, m, d, 1'b0, exp, req);
  endtask

  task automatic idle(input string req);
    step(1'b0, 3'b000, 5'd0, 4'd0, 32'd0, 1'b0, NONE, req);
  endtask

  task automatic flush(input string req);
    idle(req); idle(req);
    h1_v = 0; h2_v = 0;
  endtask

  task automatic expect_ent(input logic d, input logic [4:0] id, input logic [3:0] m, input logic [31:0] info);
    exq[exn] = {d, id, m, info};
    exn++;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < exn; i++) begin
      @(negedge clk);
      chk(req, "q_valid", 64'(q_valid), 64'd1);
      chk(req, "entry", 64'({q_is_data, q_id, q_mask, q_info}), 64'(exq[i]));
      q_ready = 1'b1;
    end
    @(negedge clk);
    q_ready = 1'b0;
    chk(req, "q_valid empty", 64'(q_valid), 64'd0);
    exn = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R2", "reset cnf", 64'(cnf_code), 64'(NONE));
    chk("R9", "reset q_valid", 64'(q_valid), 64'd0);
  endtask

  task automatic t_reads();
    cmd(4'd1, 10, 5'd3, ACK, "R4");
    cmd(4'd2, 11, 5'd4, ACK, "R4");
    cmd(4'd3, 12, 5'd5, ACK, "R4");
    flush("R2");
    expect_ent(0, 5'd3, 4'hF, {4'd1, 28'd10});
    expect_ent(0, 5'd4, 4'hF, {4'd2, 28'd11});
    expect_ent(0, 5'd5, 4'hF, {4'd3, 28'd12});
    drain("R9");
  endtask

  task automatic t_parity();
    step(1'b1, T_CMD, 5'd7, 4'hF, {4'd1, 28'd20}, 1'b1, ERR, "R1");
    cmd(4'd1, 21, 5'd8, ACK, "R1");
    idle("R2");
    flush("R1");
    expect_ent(0, 5'd8, 4'hF, {4'd1, 28'd21});
    drain("R1");
  endtask

  task automatic t_decode();
    step(1'b1, 3'b111, 5'd1, 4'hF, {4'd1, 28'd5}, 1'b0, ERR, "R3");
    dat(32'hDEAD_BEEF, 4'h3, 5'd1, ERR, "R3");
    cmd(4'd0, 5, 5'd1, ERR, "R4");
    cmd(4'd7, 5, 5'd1, ERR, "R4");
    cmd(4'd15, 5, 5'd1, ERR, "R4");
    flush("R3");
    drain("R3");
  endtask

  task automatic t_range();
    cmd(4'd1, MEMW, 5'd2, NONE, "R5");
    cmd(4'd6, MEMW + 7, 5'd2, NONE, "R5");
    cmd(4'd3, MEMW - 1, 5'd2, ACK, "R5");
    flush("R5");
    expect_ent(0, 5'd2, 4'hF, {4'd3, 28'(MEMW - 1)});
    drain("R5");
  endtask

  task automatic t_quad_write();
    cmd(4'd6, 40, 5'd9, ACK, "R7");
    dat(32'h1111_0001, 4'hC, 5'd9, ACK, "R7");
    dat(32'h2222_0002, 4'h3, 5'd9, ACK, "R7");
    chk("R7", "no partial after cmd", 64'(q_valid), 64'd0);
    idle("R7");
    chk("R7", "no partial after data1", 64'(q_valid), 64'd0);
    idle("R7");
    chk("R7", "visible after data2", 64'(q_valid), 64'd1);
    h1_v = 0; h2_v = 0;
    expect_ent(0, 5'd9, 4'hF, {4'd6, 28'd40});
    expect_ent(1, 5'd9, 4'hC, 32'h1111_0001);
    expect_ent(1, 5'd9, 4'h3, 32'h2222_0002);
    drain("R7");
  endtask

  task automatic t_busy();
    cmd(4'd1, 1, 5'd10, ACK, "R6");
    cmd(4'd1, 2, 5'd11, ACK, "R6");
    cmd(4'd2, 3, 5'd12, ACK, "R6");
    cmd(4'd4, 4, 5'd13, BSY, "R6");
    dat(32'hAAAA_5555, 4'h1, 5'd13, ERR, "R3");
    cmd(4'd3, 5, 5'd14, ACK, "R10");
    cmd(4'd1, 6, 5'd15, BSY, "R10");
    flush("R6");
    expect_ent(0, 5'd10, 4'hF, {4'd1, 28'd1});
    expect_ent(0, 5'd11, 4'hF, {4'd1, 28'd2});
    expect_ent(0, 5'd12, 4'hF, {4'd2, 28'd3});
    expect_ent(0, 5'd14, 4'hF, {4'd3, 28'd5});
    drain("R10");
  endtask

  task automatic t_abort();
    cmd(4'd6, 50, 5'd16, ACK, "R8");
    dat(32'h0000_0050, 4'hF, 5'd16, ACK, "R8");
    idle("R8");
    cmd(4'd4, 51, 5'd17, ACK, "R8");
    cmd(4'd1, 52, 5'd17, ERR, "R8");
    cmd(4'd5, 53, 5'd18, ACK, "R8");
    step(1'b1, T_DAT, 5'd18, 4'h1, 32'h0000_0053, 1'b1, ERR, "R8");
    idle("R8");
    chk("R8", "nothing left after aborts", 64'(q_valid), 64'd0);
    cmd(4'd6, 60, 5'd19, ACK, "R10");
    dat(32'h6000_0001, 4'h8, 5'd19, ACK, "R10");
    dat(32'h6000_0002, 4'h4, 5'd19, ACK, "R10");
    cmd(4'd1, 61, 5'd20, ACK, "R10");
    flush("R10");
    expect_ent(0, 5'd19, 4'hF, {4'd6, 28'd60});
    expect_ent(1, 5'd19, 4'h8, 32'h6000_0001);
    expect_ent(1, 5'd19, 4'h4, 32'h6000_0002);
    expect_ent(0, 5'd20, 4'hF, {4'd1, 28'd61});
    drain("R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reads();
    t_parity();
    t_decode();
    t_range();
    t_quad_write();
    t_busy();
    t_abort();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule